// File: doc/BRIEF.md
# Stereo Serial Audio Link Port

This block drives one stereo serial audio link from a single fast core clock. It generates the bit clock and the left/right word-select, shifts out two stereo output streams (a main pair and a surround pair), and shifts in one stereo input stream. Every timing event is an enable derived from a divider, so the whole block runs in one clock domain. The bit clock is high for the first half of each bit period and low for the second. Output data and word-select change only when the bit clock falls. Input data is sampled when it rises.

Each frame has 64 bit clocks: a left slot of 32 followed by a right slot of 32. Two slot framings are available, selected by a mode input. In the standard framing the most significant bit follows the word-select change by one bit clock. In the right-justified framing the least significant bit lands on the last bit clock of the slot. The output word length is 16, 18 or 20 bits. On the main output and on the input, an optional 12-bit side field can follow the sample's least significant bit. Left and right each carry their own side field.

On the system side there are parallel sample registers and a one-cycle frame strobe. At the strobe, the samples received in the frame that just ended are presented. In the same cycle the sample and mode inputs are captured for the frame that starts.

Top module: `audio_serial_port`

## Requirements
- R1: The bit clock period is DIV core cycles (default 16), with DIV/2 cycles high followed by DIV/2 low. A frame is 64 bit clocks.
- R2: Word-select is 0 during the 32 bit clocks of the left slot and 1 during the 32 bit clocks of the right slot. It changes only in the cycle in which the bit clock falls.
- R3: Both serial outputs change only in the cycle in which the bit clock falls. The serial input is sampled in the cycle in which the bit clock rises.
- R4: With fmt_rj=0 (standard framing), the first bit of a word is sent at slot position 1, where position 0 is the first bit clock after the word-select change. A word of 32 bits loses its final bit, because only positions 1 to 31 are available.
- R5: With fmt_rj=1 (right-justified framing), a word of length L occupies slot positions 32-L to 31, so its last bit is at position 31.
- R6: word_sel selects the output sample length: 0 gives 16 bits, 1 gives 18 bits, and 2 or 3 give 20 bits. Samples enter as 20-bit values and the top bits are used. Every bit is sent most significant first, and slot positions outside the word are 0. The surround output never carries the side field.
- R7: With aux_en=1, the main output word is the sample followed by the 12-bit side field (aux_l or aux_r), most significant bit first.
- R8: The input word is 16 data bits, followed by a 12-bit side field when aux_en=1. It uses the same framing as the outputs. rx_l/rx_r carry the data and rx_aux_l/rx_aux_r carry the side field, which reads 0 when aux_en=0.
- R9: frame_stb is high for exactly one core cycle, in the cycle in which word-select falls at the end of the right slot. The rx outputs change only in that cycle.
- R10: The sample inputs, fmt_rj, word_sel and aux_en are captured at frame_stb and govern the whole next frame. Changes made during a frame have no effect on that frame's output.
- R11: During reset, bclk, ws, both serial outputs, frame_stb and all rx outputs are 0. The first frame after reset is sent as all zeros, in standard framing with 16-bit words and no side field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_rj | input | 1 | Framing: 0 standard, 1 right-justified |
| word_sel | input | 2 | Output sample length select |
| aux_en | input | 1 | Enable the 12-bit side field on main output and input |
| main_l | input | 20 | Main left sample |
| main_r | input | 20 | Main right sample |
| surr_l | input | 20 | Surround left sample |
| surr_r | input | 20 | Surround right sample |
| aux_l | input | 12 | Side field sent in the main left slot |
| aux_r | input | 12 | Side field sent in the main right slot |
| sdin | input | 1 | Serial input data |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word-select, 0 for left and 1 for right |
| sd_main | output | 1 | Main serial output |
| sd_surr | output | 1 | Surround serial output |
| rx_l | output | 16 | Received left sample |
| rx_r | output | 16 | Received right sample |
| rx_aux_l | output | 12 | Received left side field |
| rx_aux_r | output | 12 | Received right side field |
| frame_stb | output | 1 | One-cycle pulse at each frame boundary |

## Verification
Samples captured at a frame strobe start to appear on the serial outputs at the falling bit-clock edge that comes with that same strobe. From there they occupy the following 64 bit clocks. The bench therefore compares the whole captured frame at the next strobe, not single bits. Data driven into sdin becomes visible on the rx outputs in the strobe cycle that closes the frame. Each bit is sampled at the rising bit-clock edge, half a bit period after the bench changed it. Every port is read on the falling core-clock edge, so a value registered at an enable edge is seen exactly one half core cycle later. Edge alignment of word-select and data is checked on every core cycle against the bit-clock transition seen in that same cycle.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int SLOT_BITS = 32;
    localparam int SLOT_AW   = $clog2(SLOT_BITS);
    localparam int LEN_W     = $clog2(SLOT_BITS + 1);
    localparam int SAMPLE_W  = 20;
    localparam int RX_W      = 16;
    localparam int AUX_W     = 12;
    localparam int RXS_W     = RX_W + AUX_W;

    typedef enum logic {
        FMT_STD = 1'b0,
        FMT_RJ  = 1'b1
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] wsel;
        logic       aux_en;
    } cfg_t;

    typedef logic [SLOT_BITS-1:0] slot_word_t;

    // number of sample bits selected by the word length code
    function automatic logic [LEN_W-1:0] data_len(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return LEN_W'(16);
            2'd1:    return LEN_W'(18);
            default: return LEN_W'(20);
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] tx_len(input cfg_t c, input logic with_aux);
        return data_len(c.wsel) + ((with_aux && c.aux_en) ? LEN_W'(AUX_W) : LEN_W'(0));
    endfunction

    function automatic logic [LEN_W-1:0] rx_len(input logic aux_en);
        return LEN_W'(RX_W) + (aux_en ? LEN_W'(AUX_W) : LEN_W'(0));
    endfunction

    // right-aligned transmit word: top sample bits, then the side field
    function automatic slot_word_t build_word(input logic [SAMPLE_W-1:0] s,
                                              input logic [AUX_W-1:0]    a,
                                              input cfg_t                c,
                                              input logic                with_aux);
        slot_word_t w;
        w = slot_word_t'(s) >> (LEN_W'(SAMPLE_W) - data_len(c.wsel));
        if (with_aux && c.aux_en)
            w = (w << AUX_W) | slot_word_t'(a);
        return w;
    endfunction

    function automatic logic [LEN_W-1:0] first_pos(input fmt_e f, input logic [LEN_W-1:0] len);
        return (f == FMT_RJ) ? (LEN_W'(SLOT_BITS) - len) : LEN_W'(1);
    endfunction

    function automatic logic in_word(input logic [SLOT_AW-1:0] p, input fmt_e f,
                                     input logic [LEN_W-1:0] len);
        logic [LEN_W-1:0] pe;
        logic [LEN_W-1:0] st;
        pe = {1'b0, p};
        st = first_pos(f, len);
        return (pe >= st) && ((pe - st) < len);
    endfunction

    function automatic logic word_bit(input slot_word_t w, input logic [SLOT_AW-1:0] p,
                                      input fmt_e f, input logic [LEN_W-1:0] len);
        logic [LEN_W-1:0] idx;
        if (!in_word(p, f, len))
            return 1'b0;
        idx = len - LEN_W'(1) - ({1'b0, p} - first_pos(f, len));
        return w[idx[SLOT_AW-1:0]];
    endfunction

endpackage

// File: rtl/asp_bitclk.sv
module asp_bitclk
    import asp_pkg::*;
#(
    parameter int DIV   = 16,
    parameter int POS_W = SLOT_AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic             bclk,
    output logic             rise_ev,
    output logic             fall_ev,
    output logic             wrap,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_nxt
);
    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);

    logic [CW-1:0] div_cnt;

    assign rise_ev = (div_cnt == CW'(HALF - 1));
    assign fall_ev = (div_cnt == CW'(DIV - 1));
    assign pos_nxt = pos + POS_W'(1);
    assign wrap    = fall_ev && (&pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            bclk    <= 1'b0;
            pos     <= '0;
        end else begin
            div_cnt <= fall_ev ? '0 : div_cnt + CW'(1);
            if (rise_ev)
                bclk <= 1'b1;
            if (fall_ev) begin
                bclk <= 1'b0;
                pos  <= pos_nxt;
            end
        end
    end
endmodule

// File: rtl/asp_tx_lane.sv
module asp_tx_lane
    import asp_pkg::*;
#(
    parameter bit WITH_AUX = 1'b1,
    parameter int POS_W    = SLOT_AW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall_ev,
    input  logic                wrap,
    input  logic [POS_W-1:0]    pos_nxt,
    input  cfg_t                cfg_nxt,
    input  logic [SAMPLE_W-1:0] samp_l,
    input  logic [SAMPLE_W-1:0] samp_r,
    input  logic [AUX_W-1:0]    side_l,
    input  logic [AUX_W-1:0]    side_r,
    output logic                sd
);
    slot_word_t       word_l, word_r;
    slot_word_t       nxt_l, nxt_r, cur;
    logic [LEN_W-1:0] len;

    always_comb begin
        nxt_l = wrap ? build_word(samp_l, side_l, cfg_nxt, WITH_AUX) : word_l;
        nxt_r = wrap ? build_word(samp_r, side_r, cfg_nxt, WITH_AUX) : word_r;
        cur   = pos_nxt[POS_W-1] ? nxt_r : nxt_l;
        len   = tx_len(cfg_nxt, WITH_AUX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_l <= '0;
            word_r <= '0;
            sd     <= 1'b0;
        end else begin
            if (wrap) begin
                word_l <= nxt_l;
                word_r <= nxt_r;
            end
            if (fall_ev)
                sd <= word_bit(cur, pos_nxt[SLOT_AW-1:0], cfg_nxt.fmt, len);
        end
    end
endmodule

// File: rtl/asp_rx_lane.sv
module asp_rx_lane
    import asp_pkg::*;
#(
    parameter int POS_W = SLOT_AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_ev,
    input  logic             fall_ev,
    input  logic             wrap,
    input  logic [POS_W-1:0] pos,
    input  fmt_e             fmt,
    input  logic             aux_en,
    input  logic             sdin,
    output logic [RX_W-1:0]  rx_l,
    output logic [RX_W-1:0]  rx_r,
    output logic [AUX_W-1:0] rx_aux_l,
    output logic [AUX_W-1:0] rx_aux_r
);
    logic [RXS_W-1:0] sh, left_sh;
    logic             take;
    logic             left_end;

    assign take     = rise_ev && in_word(pos[SLOT_AW-1:0], fmt, rx_len(aux_en));
    assign left_end = fall_ev && (pos == POS_W'(SLOT_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            left_sh  <= '0;
            rx_l     <= '0;
            rx_r     <= '0;
            rx_aux_l <= '0;
            rx_aux_r <= '0;
        end else begin
            if (take)
                sh <= {sh[RXS_W-2:0], sdin};
            if (left_end)
                left_sh <= sh;
            if (wrap) begin
                if (aux_en) begin
                    rx_l     <= left_sh[RXS_W-1:AUX_W];
                    rx_r     <= sh[RXS_W-1:AUX_W];
                    rx_aux_l <= left_sh[AUX_W-1:0];
                    rx_aux_r <= sh[AUX_W-1:0];
                end else begin
                    rx_l     <= left_sh[RX_W-1:0];
                    rx_r     <= sh[RX_W-1:0];
                    rx_aux_l <= '0;
                    rx_aux_r <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
    import asp_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_rj,
    input  logic [1:0]          word_sel,
    input  logic                aux_en,
    input  logic [SAMPLE_W-1:0] main_l,
    input  logic [SAMPLE_W-1:0] main_r,
    input  logic [SAMPLE_W-1:0] surr_l,
    input  logic [SAMPLE_W-1:0] surr_r,
    input  logic [AUX_W-1:0]    aux_l,
    input  logic [AUX_W-1:0]    aux_r,
    input  logic                sdin,
    output logic                bclk,
    output logic                ws,
    output logic                sd_main,
    output logic                sd_surr,
    output logic [RX_W-1:0]     rx_l,
    output logic [RX_W-1:0]     rx_r,
    output logic [AUX_W-1:0]    rx_aux_l,
    output logic [AUX_W-1:0]    rx_aux_r,
    output logic                frame_stb
);
    localparam int POS_W  = SLOT_AW + 1;
    localparam int NLANES = 2;

    logic             rise_ev, fall_ev, wrap;
    logic [POS_W-1:0] pos, pos_nxt;
    cfg_t             cfg_q, cfg_in, cfg_nxt;

    logic [SAMPLE_W-1:0] lane_sl [NLANES];
    logic [SAMPLE_W-1:0] lane_sr [NLANES];
    logic [AUX_W-1:0]    lane_al [NLANES];
    logic [AUX_W-1:0]    lane_ar [NLANES];
    logic                lane_sd [NLANES];

    asp_bitclk #(.DIV(DIV), .POS_W(POS_W)) u_bitclk (
        .clk     (clk),
        .rst     (rst),
        .bclk    (bclk),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .wrap    (wrap),
        .pos     (pos),
        .pos_nxt (pos_nxt)
    );

    // mode is taken at the frame boundary only (R10)
    assign cfg_in  = '{fmt: fmt_e'(fmt_rj), wsel: word_sel, aux_en: aux_en};
    assign cfg_nxt = wrap ? cfg_in : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '{fmt: FMT_STD, wsel: 2'd0, aux_en: 1'b0};
            ws        <= 1'b0;
            frame_stb <= 1'b0;
        end else begin
            cfg_q     <= cfg_nxt;
            frame_stb <= wrap;
            if (fall_ev)
                ws <= pos_nxt[POS_W-1];
        end
    end

    assign lane_sl[0] = main_l;
    assign lane_sr[0] = main_r;
    assign lane_al[0] = aux_l;
    assign lane_ar[0] = aux_r;
    assign lane_sl[1] = surr_l;
    assign lane_sr[1] = surr_r;
    assign lane_al[1] = '0;
    assign lane_ar[1] = '0;

    generate
        for (genvar g = 0; g < NLANES; g++) begin : g_lane
            asp_tx_lane #(.WITH_AUX(g == 0), .POS_W(POS_W)) u_tx (
                .clk     (clk),
                .rst     (rst),
                .fall_ev (fall_ev),
                .wrap    (wrap),
                .pos_nxt (pos_nxt),
                .cfg_nxt (cfg_nxt),
                .samp_l  (lane_sl[g]),
                .samp_r  (lane_sr[g]),
                .side_l  (lane_al[g]),
                .side_r  (lane_ar[g]),
                .sd      (lane_sd[g])
            );
        end
    endgenerate

    assign sd_main = lane_sd[0];
    assign sd_surr = lane_sd[1];

    asp_rx_lane #(.POS_W(POS_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .wrap     (wrap),
        .pos      (pos),
        .fmt      (cfg_q.fmt),
        .aux_en   (cfg_q.aux_en),
        .sdin     (sdin),
        .rx_l     (rx_l),
        .rx_r     (rx_r),
        .rx_aux_l (rx_aux_l),
        .rx_aux_r (rx_aux_r)
    );
endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
    parameter int DIV = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        bclk,
    input logic        ws,
    input logic        sd_main,
    input logic        sd_surr,
    input logic        frame_stb,
    input logic [15:0] rx_l,
    input logic [15:0] rx_r
);
    localparam int GW = $clog2(DIV) + 1;

    logic [GW-1:0] gap;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if ($rose(bclk)) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap <= gap + GW'(1);
        end
    end

    AST_BCLK_PERIOD: assert property (@(posedge clk) disable iff (rst)
        ($rose(bclk) && seen) |-> (gap == GW'(DIV - 1)));              // R1
    AST_BCLK_DUTY: assert property (@(posedge clk) disable iff (rst)
        ($fell(bclk) && seen) |-> (gap == GW'(DIV / 2 - 1)));          // R1
    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws) |-> $fell(bclk));                                 // R2
    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sd_main) || !$stable(sd_surr)) |-> $fell(bclk));     // R3
    AST_STB_AT_WS_FALL: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> ($fell(ws) && $fell(bclk)));                     // R9
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> !frame_stb);                                     // R9
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$stable(rx_l) || !$stable(rx_r)) |-> frame_stb);             // R9
endmodule

bind audio_serial_port asp_checker #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bclk      (bclk),
    .ws        (ws),
    .sd_main   (sd_main),
    .sd_surr   (sd_surr),
    .frame_stb (frame_stb),
    .rx_l      (rx_l),
    .rx_r      (rx_r)
);

// File: tb/audio_serial_port_tb.sv
module audio_serial_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 16;
    localparam int NFRAMES    = 36;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic        fmt;
        logic [1:0]  wsel;
        logic        aux;
        logic [19:0] ml, mr, sl, sr;
        logic [11:0] al, ar;
        logic [15:0] rl, rr;
        logic [11:0] ral, rar;
    } frame_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_rj = 1'b0;
    logic [1:0]  word_sel = 2'd0;
    logic        aux_en = 1'b0;
    logic [19:0] main_l = '0, main_r = '0, surr_l = '0, surr_r = '0;
    logic [11:0] aux_l = '0, aux_r = '0;
    logic        sdin = 1'b0;
    logic        bclk, ws, sd_main, sd_surr, frame_stb;
    logic [15:0] rx_l, rx_r;
    logic [11:0] rx_aux_l, rx_aux_r;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    audio_serial_port #(.DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .fmt_rj(fmt_rj), .word_sel(word_sel), .aux_en(aux_en),
        .main_l(main_l), .main_r(main_r), .surr_l(surr_l), .surr_r(surr_r),
        .aux_l(aux_l), .aux_r(aux_r), .sdin(sdin),
        .bclk(bclk), .ws(ws), .sd_main(sd_main), .sd_surr(sd_surr),
        .rx_l(rx_l), .rx_r(rx_r), .rx_aux_l(rx_aux_l), .rx_aux_r(rx_aux_r),
        .frame_stb(frame_stb)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected bit at slot position p for a word of n sample bits (+12 side bits)
    function automatic logic slot_bit(input logic [19:0] s, input logic [11:0] a,
                                      input logic use_aux, input logic [1:0] wsel,
                                      input logic fmt, input int p);
        int n, len, st, k;
        n   = (wsel == 2'd0) ? 16 : (wsel == 2'd1) ? 18 : 20;
        len = n + (use_aux ? 12 : 0);
        st  = fmt ? 32 - len : 1;
        k   = p - st;
        if (k < 0 || k >= len) return 1'b0;
        if (k < n) return s[19-k];
        return a[11-(k-n)];
    endfunction

    function automatic frame_t pick_frame(input int idx);
        frame_t f;
        f.fmt = 1'($urandom_range(0, 1));
        f.wsel = 2'($urandom_range(0, 3));
        f.aux = 1'($urandom_range(0, 1));
        f.ml = 20'($urandom); f.mr = 20'($urandom);
        f.sl = 20'($urandom); f.sr = 20'($urandom);
        f.al = 12'($urandom); f.ar = 12'($urandom);
        f.rl = '0; f.rr = '0; f.ral = '0; f.rar = '0;
        case (idx)
            0: begin f.fmt = 0; f.wsel = 2; f.aux = 1; f.ml = '1; f.mr = '1; f.al = '1; f.ar = '1; end
            1: begin f.fmt = 1; f.wsel = 2; f.aux = 1; f.ml = 20'hAAAAA; f.mr = 20'h55555; end
            2: begin f.fmt = 1; f.wsel = 0; f.aux = 0; f.ml = 20'h80001; f.mr = 20'h0000F; end
            3: begin f.fmt = 0; f.wsel = 1; f.aux = 0; f.ml = 20'h00003; f.mr = 20'h80000; end
            4: begin f.fmt = 1; f.wsel = 3; f.aux = 1; f.al = 12'h001; f.ar = 12'h800; end
            5: begin f.fmt = 0; f.wsel = 0; f.aux = 1; f.sl = '1; f.sr = '1; end
            default: ;
        endcase
        return f;
    endfunction

    task automatic apply(input frame_t f);
        fmt_rj = f.fmt; word_sel = f.wsel; aux_en = f.aux;
        main_l = f.ml; main_r = f.mr; surr_l = f.sl; surr_r = f.sr;
        aux_l = f.al; aux_r = f.ar;
    endtask

    initial begin
        frame_t cur, pend;
        logic [63:0] cap_main, cap_surr, cap_ws, exp_main, exp_surr, exp_ws;
        logic prev_bclk, prev_stb, prev_sdm, prev_sds, prev_ws;
        logic [15:0] prev_rl, prev_rr;
        int bpos, gap, gap_viol, edge_viol, rx_viol, frames, cyc;
        bit seen_rise, timed_out;
        int dummy;
        string tag;

        dummy = $urandom(32'h5EED1234);
        cur = '0;
        cur.rl = 16'($urandom); cur.rr = 16'($urandom);
        pend = pick_frame(0);
        apply(pend);
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // reset state (R11)
        check(bclk == 0 && ws == 0 && sd_main == 0 && sd_surr == 0 && frame_stb == 0,
              "R11 reset outputs", {59'd0, bclk, ws, sd_main, sd_surr, frame_stb}, 64'd0);
        check(rx_l == 0 && rx_r == 0 && rx_aux_l == 0 && rx_aux_r == 0,
              "R11 reset rx", {rx_l, rx_r, rx_aux_l, rx_aux_r, 8'd0}, 64'd0);

        cap_main = '0; cap_surr = '0; cap_ws = '0;
        prev_bclk = 0; prev_stb = 0; prev_sdm = 0; prev_sds = 0; prev_ws = 0;
        prev_rl = '0; prev_rr = '0;
        bpos = 0; gap = 0; gap_viol = 0; edge_viol = 0; rx_viol = 0;
        frames = 0; cyc = 0; seen_rise = 0; timed_out = 0;

        while (frames < NFRAMES) begin
            @(negedge clk);
            cyc++;
            gap++;
            if (cyc > WATCHDOG) begin
                timed_out = 1;
                break;
            end
            if ((sd_main !== prev_sdm || sd_surr !== prev_sds || ws !== prev_ws)
                && !(prev_bclk && !bclk))
                edge_viol++;
            if ((rx_l !== prev_rl || rx_r !== prev_rr) && !frame_stb)
                rx_viol++;
            if (frame_stb) begin
                check(!prev_stb, "R9 strobe width", 64'(prev_stb), 64'd0);
                for (int q = 0; q < 64; q++) begin
                    exp_main[q] = slot_bit(q < 32 ? cur.ml : cur.mr, q < 32 ? cur.al : cur.ar,
                                           cur.aux, cur.wsel, cur.fmt, q % 32);
                    exp_surr[q] = slot_bit(q < 32 ? cur.sl : cur.sr, 12'd0, 1'b0,
                                           cur.wsel, cur.fmt, q % 32);
                    exp_ws[q]   = (q >= 32);
                end
                tag = cur.aux ? "R7" : (cur.fmt ? "R5" : "R4");
                check(bpos == 64 && gap_viol == 0, "R1 bit clocks per frame",
                      64'(bpos), 64'd64);
                check(cap_ws == exp_ws, "R2 word-select", cap_ws, exp_ws);
                check(edge_viol == 0, "R3 change off falling edge", 64'(edge_viol), 64'd0);
                check(cap_main == exp_main, {tag, " R10 main frame"}, cap_main, exp_main);
                check(cap_surr == exp_surr, "R6 surround frame", cap_surr, exp_surr);
                check(rx_l == cur.rl && rx_r == cur.rr, "R8 rx data",
                      {32'd0, rx_l, rx_r}, {32'd0, cur.rl, cur.rr});
                check(rx_aux_l == (cur.aux ? cur.ral : 12'd0) &&
                      rx_aux_r == (cur.aux ? cur.rar : 12'd0), "R8 rx side field",
                      {40'd0, rx_aux_l, rx_aux_r},
                      {40'd0, cur.aux ? cur.ral : 12'd0, cur.aux ? cur.rar : 12'd0});
                check(rx_viol == 0, "R9 rx changed off strobe", 64'(rx_viol), 64'd0);
                frames++;
                cur = pend;
                cur.rl = 16'($urandom); cur.rr = 16'($urandom);
                cur.ral = 12'($urandom); cur.rar = 12'($urandom);
                pend = pick_frame(frames);
                apply(pend);
                bpos = 0; gap_viol = 0; edge_viol = 0; rx_viol = 0;
                cap_main = '0; cap_surr = '0; cap_ws = '0;
            end
            if (bclk && !prev_bclk) begin
                if (seen_rise && gap != DIV) gap_viol++;
                seen_rise = 1; gap = 0;
                if (bpos < 64) begin
                    cap_main[bpos] = sd_main;
                    cap_surr[bpos] = sd_surr;
                    cap_ws[bpos]   = ws;
                end
                bpos++;
            end
            if (!bclk && prev_bclk && bpos < 64)
                sdin = slot_bit({bpos < 32 ? cur.rl : cur.rr, 4'd0},
                                bpos < 32 ? cur.ral : cur.rar, cur.aux, 2'd0,
                                cur.fmt, bpos % 32);
            prev_bclk = bclk; prev_stb = frame_stb;
            prev_sdm = sd_main; prev_sds = sd_surr; prev_ws = ws;
            prev_rl = rx_l; prev_rr = rx_r;
        end

        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule